// File: doc/BRIEF.md
# Per-Block Write Lock Controller

This block holds a write-protection state for every erase block of a flash array. Each block is either open for writing, locked, or tight-locked. A tight-locked block can only return to another state through a cold reset. Four sweep commands act on the array. Three of them walk a block range taken from two range registers: open, lock and tight-lock. The fourth opens every block, starting at block zero. The sweep handles one block per clock.

Each written block also copies its new state into a write-protection status register. A separate query port returns the current state of any block without a clock, so outside logic can gate program and erase operations with it. When a sweep finishes, the block raises a one-cycle completion pulse, which is the signal for setting the master interrupt flag. A range error flag travels with that pulse. While a sweep runs, the block reports busy and refuses new commands.

Top module: `blk_lock_ctrl`

## Requirements
- R1: After a cold reset every block reads locked on the query port, the status register reads 0x0002, and busy, done and err are low.
- R2: Block states are one-hot three-bit codes: tight-locked 3'b001, locked 3'b010, open 3'b100. The query port returns the state of block q_idx_i in the same cycle.
- R3: A range-start write stores the low IDXW bits of the write data into both the start and end registers. A range-end write changes only the end register.
- R4: Command 0x23 sets blocks start..end to open, in ascending order. It stops at the first tight-locked block, which is left unchanged together with every block after it.
- R5: Command 0x2A sets blocks start..end to locked, with the same stop rule at the first tight-locked block.
- R6: Command 0x27 opens blocks from index 0 up to the last block and stops at the first tight-locked block. It ignores the range registers.
- R7: Command 0x2C sets blocks start..end to tight-locked and skips, without changing, every block that is open.
- R8: A ranged sweep that reaches an index equal to or above NUM_BLOCKS stops there. It raises err_o together with done_o, and the blocks written before that point keep their new states.
- R9: The status register takes the state code of the last block a sweep wrote. It keeps its value when a sweep writes no block.
- R10: busy_o is high from the cycle after a command is accepted until the sweep ends, and done_o pulses for one cycle as busy_o falls. A sweep whose start is greater than its end completes without changing any block.
- R11: A command presented while busy, or any code other than the four sweep commands, has no effect: no done pulse, no block change and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 8 | Command code |
| rng_start_we_i | input | 1 | Range-start register write |
| rng_end_we_i | input | 1 | Range-end register write |
| rng_wdata_i | input | DATA_W | Range register write data |
| rng_start_o | output | IDXW | Range-start register value |
| rng_end_o | output | IDXW | Range-end register value |
| wp_status_o | output | DATA_W | Write-protection status register |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle sweep completion pulse |
| err_o | output | 1 | Range error, valid with done_o |
| q_idx_i | input | IDXW | Query block index |
| q_state_o | output | 3 | State of the queried block |

## Verification
The bench builds the block with NUM_BLOCKS = 12. Because 12 is not a power of two, the four-bit range field can hold indices 12 to 15, which are beyond the array. A tight-lock sweep over 10..14 therefore reaches the range error after writing two blocks. The small array also keeps the full-array open sweep short, so the bench can compare every block against its model after each command. Those checks cover a sweep stopping at a tight-locked block, a tight-lock sweep skipping open blocks, an empty range, and a command presented in the middle of a sweep.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

    typedef enum logic [2:0] {
        BLK_TIGHT  = 3'b001,
        BLK_LOCKED = 3'b010,
        BLK_OPEN   = 3'b100
    } blk_state_e;

    localparam logic [7:0] OP_OPEN_RANGE  = 8'h23;
    localparam logic [7:0] OP_OPEN_ALL    = 8'h27;
    localparam logic [7:0] OP_LOCK_RANGE  = 8'h2A;
    localparam logic [7:0] OP_TIGHT_RANGE = 8'h2C;

    typedef enum logic [1:0] {
        SW_OPEN,
        SW_LOCK,
        SW_TIGHT
    } sweep_op_e;

endpackage

// File: rtl/blk_lock_range.sv
module blk_lock_range #(
    parameter int IDXW   = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_we_i,
    input  logic              end_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [IDXW-1:0]   start_o,
    output logic [IDXW-1:0]   end_o
);

    typedef struct packed {
        logic [IDXW-1:0] first;
        logic [IDXW-1:0] last;
    } rng_t;

    rng_t rng_d, rng_q;

    always_comb begin
        rng_d = rng_q;
        if (end_we_i) begin
            rng_d.last = wdata_i[IDXW-1:0];
        end
        // a start write also seeds the end so a single write selects one block
        if (start_we_i) begin
            rng_d.first = wdata_i[IDXW-1:0];
            rng_d.last  = wdata_i[IDXW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rng_q <= '0;
        end else begin
            rng_q <= rng_d;
        end
    end

    assign start_o = rng_q.first;
    assign end_o   = rng_q.last;

endmodule

// File: rtl/blk_lock_array.sv
module blk_lock_array
    import blk_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 64,
    parameter int IDXW       = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [IDXW-1:0] wr_idx_i,
    input  logic [2:0]      wr_state_i,
    input  logic [IDXW-1:0] rd_idx_i,
    output logic [2:0]      rd_state_o,
    input  logic [IDXW-1:0] q_idx_i,
    output logic [2:0]      q_state_o
);

    localparam logic [IDXW:0] NB = (IDXW+1)'(NUM_BLOCKS);

    logic [2:0] blk_d [NUM_BLOCKS];
    logic [2:0] blk_q [NUM_BLOCKS];

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
        always_comb begin
            blk_d[g] = blk_q[g];
            if (wr_en_i && (wr_idx_i == IDXW'(g))) begin
                blk_d[g] = wr_state_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                blk_q[g] <= BLK_LOCKED;
            end else begin
                blk_q[g] <= blk_d[g];
            end
        end
    end

    // indices past the array read as locked so the sweep never sees X
    always_comb begin
        rd_state_o = BLK_LOCKED;
        if ({1'b0, rd_idx_i} < NB) begin
            rd_state_o = blk_q[rd_idx_i];
        end
        q_state_o = BLK_LOCKED;
        if ({1'b0, q_idx_i} < NB) begin
            q_state_o = blk_q[q_idx_i];
        end
    end

endmodule

// File: rtl/blk_lock_seq.sv
module blk_lock_seq
    import blk_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 64,
    parameter int IDXW       = 6,
    parameter int DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [7:0]        cmd_code_i,
    input  logic [IDXW-1:0]   rng_start_i,
    input  logic [IDXW-1:0]   rng_end_i,
    input  logic [2:0]        cur_state_i,
    output logic [IDXW-1:0]   rd_idx_o,
    output logic              wr_en_o,
    output logic [IDXW-1:0]   wr_idx_o,
    output logic [2:0]        wr_state_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] wp_status_o
);

    localparam logic [IDXW:0] NB       = (IDXW+1)'(NUM_BLOCKS);
    localparam logic [IDXW:0] LAST_BLK = (IDXW+1)'(NUM_BLOCKS - 1);

    typedef struct packed {
        logic              active;
        sweep_op_e         op;
        logic [IDXW:0]     idx;
        logic [IDXW:0]     last;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] wp;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        wr_en_o    = 1'b0;
        wr_state_o = BLK_LOCKED;

        if (!seq_q.active) begin
            if (cmd_valid_i) begin
                case (cmd_code_i)
                    OP_OPEN_RANGE: begin
                        seq_d.active = 1'b1;
                        seq_d.op     = SW_OPEN;
                        seq_d.idx    = {1'b0, rng_start_i};
                        seq_d.last   = {1'b0, rng_end_i};
                    end
                    OP_LOCK_RANGE: begin
                        seq_d.active = 1'b1;
                        seq_d.op     = SW_LOCK;
                        seq_d.idx    = {1'b0, rng_start_i};
                        seq_d.last   = {1'b0, rng_end_i};
                    end
                    OP_TIGHT_RANGE: begin
                        seq_d.active = 1'b1;
                        seq_d.op     = SW_TIGHT;
                        seq_d.idx    = {1'b0, rng_start_i};
                        seq_d.last   = {1'b0, rng_end_i};
                    end
                    OP_OPEN_ALL: begin
                        seq_d.active = 1'b1;
                        seq_d.op     = SW_OPEN;
                        seq_d.idx    = '0;
                        seq_d.last   = LAST_BLK;
                    end
                    default: ;
                endcase
            end
        end else if (seq_q.idx > seq_q.last) begin
            seq_d.active = 1'b0;
            seq_d.done   = 1'b1;
        end else if (seq_q.idx >= NB) begin
            seq_d.active = 1'b0;
            seq_d.done   = 1'b1;
            seq_d.err    = 1'b1;
        end else begin
            case (seq_q.op)
                SW_TIGHT: begin
                    if (cur_state_i != BLK_OPEN) begin
                        wr_en_o    = 1'b1;
                        wr_state_o = BLK_TIGHT;
                    end
                    seq_d.idx = seq_q.idx + 1'b1;
                end
                default: begin
                    if (cur_state_i == BLK_TIGHT) begin
                        seq_d.active = 1'b0;
                        seq_d.done   = 1'b1;
                    end else begin
                        wr_en_o    = 1'b1;
                        wr_state_o = (seq_q.op == SW_LOCK) ? BLK_LOCKED : BLK_OPEN;
                        seq_d.idx  = seq_q.idx + 1'b1;
                    end
                end
            endcase
            if (wr_en_o) begin
                seq_d.wp = {{(DATA_W-3){1'b0}}, wr_state_o};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q        <= '0;
            seq_q.op     <= SW_OPEN;
            seq_q.wp     <= DATA_W'(BLK_LOCKED);
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_idx_o    = seq_q.idx[IDXW-1:0];
    assign wr_idx_o    = seq_q.idx[IDXW-1:0];
    assign busy_o      = seq_q.active;
    assign done_o      = seq_q.done;
    assign err_o       = seq_q.err;
    assign wp_status_o = seq_q.wp;

endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl #(
    parameter  int NUM_BLOCKS = 64,
    parameter  int DATA_W     = 16,
    localparam int IDXW       = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [7:0]        cmd_code_i,
    input  logic              rng_start_we_i,
    input  logic              rng_end_we_i,
    input  logic [DATA_W-1:0] rng_wdata_i,
    output logic [IDXW-1:0]   rng_start_o,
    output logic [IDXW-1:0]   rng_end_o,
    output logic [DATA_W-1:0] wp_status_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    input  logic [IDXW-1:0]   q_idx_i,
    output logic [2:0]        q_state_o
);

    logic [IDXW-1:0] rd_idx;
    logic [2:0]      rd_state;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx;
    logic [2:0]      wr_state;

    blk_lock_range #(
        .IDXW   (IDXW),
        .DATA_W (DATA_W)
    ) u_range (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_we_i (rng_start_we_i),
        .end_we_i   (rng_end_we_i),
        .wdata_i    (rng_wdata_i),
        .start_o    (rng_start_o),
        .end_o      (rng_end_o)
    );

    blk_lock_array #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .IDXW       (IDXW)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_state_i (wr_state),
        .rd_idx_i   (rd_idx),
        .rd_state_o (rd_state),
        .q_idx_i    (q_idx_i),
        .q_state_o  (q_state_o)
    );

    blk_lock_seq #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .IDXW       (IDXW),
        .DATA_W     (DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid_i),
        .cmd_code_i  (cmd_code_i),
        .rng_start_i (rng_start_o),
        .rng_end_i   (rng_end_o),
        .cur_state_i (rd_state),
        .rd_idx_o    (rd_idx),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx),
        .wr_state_o  (wr_state),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o),
        .wp_status_o (wp_status_o)
    );

endmodule

// File: rtl/blk_lock_chk.sv
module blk_lock_chk #(
    parameter int NUM_BLOCKS = 64,
    parameter int DATA_W     = 16,
    parameter int IDXW       = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid_i,
    input logic [7:0]        cmd_code_i,
    input logic              rng_start_we_i,
    input logic [DATA_W-1:0] rng_wdata_i,
    input logic [IDXW-1:0]   rng_start_o,
    input logic [IDXW-1:0]   rng_end_o,
    input logic [DATA_W-1:0] wp_status_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [2:0]        q_state_o
);

    logic legal_cmd;
    assign legal_cmd = (cmd_code_i == 8'h23) || (cmd_code_i == 8'h27) ||
                       (cmd_code_i == 8'h2A) || (cmd_code_i == 8'h2C);

    // R2
    q_state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q_state_o) == 1);

    // R9
    wp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wp_status_o) == 1);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && cmd_valid_i && legal_cmd) |=> busy_o);

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R3
    start_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rng_start_we_i |=> (rng_start_o == $past(rng_wdata_i[IDXW-1:0]) &&
                            rng_end_o == $past(rng_wdata_i[IDXW-1:0])));

endmodule

bind blk_lock_ctrl blk_lock_chk #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .DATA_W     (DATA_W),
    .IDXW       (IDXW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_code_i     (cmd_code_i),
    .rng_start_we_i (rng_start_we_i),
    .rng_wdata_i    (rng_wdata_i),
    .rng_start_o    (rng_start_o),
    .rng_end_o      (rng_end_o),
    .wp_status_o    (wp_status_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .err_o          (err_o),
    .q_state_o      (q_state_o)
);

// File: tb/blk_lock_ctrl_tb.sv
module blk_lock_ctrl_tb;

    localparam int NB   = 12;
    localparam int IDXW = $clog2(NB);
    localparam int DW   = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [7:0]      cmd_code = '0;
    logic            st_we = 1'b0;
    logic            en_we = 1'b0;
    logic [DW-1:0]   wdata = '0;
    logic [IDXW-1:0] rng_start, rng_end;
    logic [DW-1:0]   wp_status;
    logic            busy, done, err;
    logic [IDXW-1:0] q_idx = '0;
    logic [2:0]      q_state;

    always #4 clk = ~clk;

    blk_lock_ctrl #(.NUM_BLOCKS(NB), .DATA_W(DW)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid_i    (cmd_valid),
        .cmd_code_i     (cmd_code),
        .rng_start_we_i (st_we),
        .rng_end_we_i   (en_we),
        .rng_wdata_i    (wdata),
        .rng_start_o    (rng_start),
        .rng_end_o      (rng_end),
        .wp_status_o    (wp_status),
        .busy_o         (busy),
        .done_o         (done),
        .err_o          (err),
        .q_idx_i        (q_idx),
        .q_state_o      (q_state)
    );

    typedef struct {
        logic          err;
        logic [DW-1:0] wp;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   ended  = 0;

    logic [2:0]    mdl [NB];
    logic [DW-1:0] mwp;
    int            mstart, mend;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    // monitor: every done pulse must match the oldest expected completion
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R11: got done pulse expected none");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R8 err flag", {31'd0, err}, {31'd0, e.err});
                chk("R9 wp status", {16'd0, wp_status}, {16'd0, e.wp});
            end
        end
    end

    // model of a sweep, built from the requirement text
    task automatic model_cmd(input logic [7:0] code);
        exp_t e;
        int lo, hi;
        e.err = 1'b0;
        lo = (code == 8'h27) ? 0 : mstart;
        hi = (code == 8'h27) ? NB - 1 : mend;
        for (int b = lo; b <= hi; b++) begin
            if (b >= NB) begin
                e.err = 1'b1;
                break;
            end
            if (code == 8'h2C) begin
                if (mdl[b] == 3'b100) continue;
                mdl[b] = 3'b001;
                mwp = 16'h0001;
            end else begin
                if (mdl[b] == 3'b001) break;
                mdl[b] = (code == 8'h2A) ? 3'b010 : 3'b100;
                mwp = {13'd0, mdl[b]};
            end
        end
        e.wp = mwp;
        exp_q.push_back(e);
    endtask

    task automatic check_all(input string req);
        for (int b = 0; b < NB; b++) begin
            q_idx = IDXW'(b);
            #1;
            chk(req, {29'd0, q_state}, {29'd0, mdl[b]});
        end
    endtask

    task automatic wr_start(input logic [DW-1:0] v);
        @(negedge clk);
        st_we = 1'b1;
        wdata = v;
        @(negedge clk);
        st_we = 1'b0;
        mstart = int'(v) % (1 << IDXW);
        mend   = mstart;
        chk("R3 start", {28'd0, rng_start}, mstart);
        chk("R3 end copy", {28'd0, rng_end}, mend);
    endtask

    task automatic wr_end(input logic [DW-1:0] v);
        @(negedge clk);
        en_we = 1'b1;
        wdata = v;
        @(negedge clk);
        en_we = 1'b0;
        mend = int'(v) % (1 << IDXW);
        chk("R3 end only", {28'd0, rng_end}, mend);
        chk("R3 start kept", {28'd0, rng_start}, mstart);
    endtask

    task automatic do_cmd(input string req, input logic [7:0] code,
                          input bit extra, input logic [7:0] extra_code);
        model_cmd(code);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        @(negedge clk);
        chk("R10 busy after accept", {31'd0, busy}, 32'd1);
        if (extra) begin
            cmd_code = extra_code;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R10 idle after sweep", {31'd0, busy}, 32'd0);
        chk({req, " queue drained"}, exp_q.size(), 0);
        check_all(req);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        for (int b = 0; b < NB; b++) mdl[b] = 3'b010;
        mwp = 16'h0002;
        mstart = 0;
        mend = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 wp reset", {16'd0, wp_status}, 32'h0002);
        chk("R1 busy reset", {31'd0, busy}, 32'd0);
        chk("R1 done reset", {30'd0, done, err}, 32'd0);
        check_all("R1 R2 reset locked");

        // R3 range registers
        wr_start(16'h0003);
        wr_end(16'h0006);
        wr_start(16'h01F5);

        // R4 open range 2..5
        wr_start(16'd2);
        wr_end(16'd5);
        do_cmd("R4 open range", 8'h23, 0, 8'h00);

        // R7 tight 4..7 skips open 4,5
        wr_start(16'd4);
        wr_end(16'd7);
        do_cmd("R7 tight skip open", 8'h2C, 0, 8'h00);

        // R5 lock 0..9 stops at tight block 6
        wr_start(16'd0);
        wr_end(16'd9);
        do_cmd("R5 lock stop at tight", 8'h2A, 0, 8'h00);

        // R6 open all stops at block 6
        do_cmd("R6 open all", 8'h27, 0, 8'h00);

        // R8 range beyond the array
        wr_start(16'd10);
        wr_end(16'd14);
        do_cmd("R8 range error", 8'h2C, 0, 8'h00);

        // R10 empty range, R9 status kept
        wr_start(16'd9);
        wr_end(16'd3);
        do_cmd("R10 R9 empty range", 8'h2A, 0, 8'h00);

        // R11 unknown code ignored
        wr_start(16'd0);
        wr_end(16'd5);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = 8'h55;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R11 unknown not busy", {31'd0, busy}, 32'd0);
        repeat (10) @(negedge clk);
        chk("R11 unknown wp kept", {16'd0, wp_status}, {16'd0, mwp});
        check_all("R11 unknown no change");

        // R11 command while busy ignored
        do_cmd("R11 busy ignore", 8'h2A, 1, 8'h2C);
        repeat (10) @(negedge clk);
        chk("R11 no second done", exp_q.size(), 0);
        check_all("R11 busy ignore final");

        finish_run();
    end

endmodule